// File: doc/BRIEF.md
# Receive Descriptor Ring Write-Back Engine

This block is the receive-side sequencer of an Ethernet MAC. It walks a ring of two-word buffer descriptors held in system memory. For each incoming frame it fetches the descriptor at its ring pointer and checks that the engine owns it. It then stores the frame's bytes into that descriptor's buffer. When the buffer is complete, it writes back a status word carrying the byte count and the frame-boundary flags. Finally it returns the descriptor to software by setting its used bit.

A frame longer than one buffer continues into the following descriptors. When the ring runs out of free descriptors, the rest of the frame is thrown away and a sticky flag is raised.

Frame bytes arrive on a valid/ready byte stream that carries start and end markers. A byte moves only on a cycle where `s_valid` and `s_ready` are both high. `s_ready` drops while the engine is fetching a descriptor or writing to memory, so the source must hold its byte and flags steady until the byte is taken. Memory is reached through a single request/grant master. A request and its address, data and strobes stay steady until `mem_gnt`. Read data is taken in the cycle the grant arrives.

Software loads the ring start with a queue-base write and turns reception on and off with `rx_en`.

Top module: `rx_ring_wb`

## Requirements
- R1: Word 0 of a descriptor holds the buffer address in bits 31:2, the wrap flag in bit 1 and the used flag in bit 0. Frame byte k of a buffer is written to buffer address + k as a single-lane write. The lane is given by bits 1:0 of that address, its strobe bit is the only one set, and the byte is replicated on all four data lanes.
- R2: When a buffer is closed, the word at descriptor address + 4 is written with the stored byte count in bits 13:0. Bit 14 is set only in a frame's first descriptor and bit 15 only in its last; all other bits are zero. This write happens before word 0 is written back.
- R3: Word 0 is then rewritten with its original address and wrap bits and with bit 0 set.
- R4: A descriptor whose used flag is set is never filled. The remainder of the frame is consumed and discarded, and `bna` goes high and stays high until the next queue-base write clears it. The ring pointer stays on that descriptor.
- R5: After a descriptor with the wrap flag set, the next descriptor is taken from the queue base. Otherwise the next one is taken from the current address + 8.
- R6: A frame longer than BUF_BYTES fills each buffer to exactly BUF_BYTES bytes and continues in the next descriptor. Only the first descriptor has the start flag and only the last has the end flag.
- R7: A frame of exactly BUF_BYTES bytes occupies a single descriptor with both flags set and a count of BUF_BYTES.
- R8: `rx_en` is sampled when a frame starts. A frame whose start arrives while `rx_en` is low is consumed with no memory access.
- R9: Bytes arriving outside a frame, with no start marker, are consumed and discarded with no memory access.
- R10: A queue-base write sets the ring pointer to the written value with bits 2:0 cleared. The next frame uses the descriptor at that address.
- R11: Out of reset no memory request is active, `bna` is low, and `s_ready` is high while no start marker is offered. A memory request that is not granted is held in the next cycle with the same address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| qbase_we | input | 1 | Queue-base write strobe |
| qbase_val | input | 32 | Queue-base address |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address (word aligned for descriptor words) |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Write byte-lane strobes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| bna | output | 1 | Sticky: a frame met a descriptor still held by software |

## Verification
The bench builds the engine with BUF_BYTES set to 16, in place of the 1536-byte default. Frames of a few dozen bytes therefore reach the exact-fit case, buffers filled to the limit, and frames spread across three or more descriptors. The ring has four descriptors. Repeated frames cross the wrap descriptor, and randomly withheld descriptors trigger mid-frame drops. Queue-base writes to interior descriptors form shorter rings whose wrap target differs from the first descriptor.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RECV,
    ST_WBYTE,
    ST_WSTAT,
    ST_WOWN,
    ST_DROP
  } rxwb_state_e;

  localparam int LEN_W   = 14;
  localparam int SOF_POS = 14;
  localparam int EOF_POS = 15;

  function automatic logic [31:0] mk_status(input logic [LEN_W-1:0] len,
                                            input logic first,
                                            input logic last);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[SOF_POS]   = first;
    w[EOF_POS]   = last;
    return w;
  endfunction
endpackage

// File: rtl/rxwb_ring_ptr.sv
module rxwb_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_val,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam int STEP = 8;

  logic [AW-1:0] base_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] aligned;

  assign aligned = {base_val[AW-1:3], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (base_we) begin
      base_q <= aligned;
      ptr_q  <= aligned;
    end else if (adv) begin
      ptr_q <= wrap ? base_q : ptr_q + AW'(STEP);
    end
  end

  assign ptr = ptr_q;

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_we && adv && wrap) |=> (ptr == base_q));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_we && adv && !wrap) |=> (ptr == $past(ptr) + AW'(STEP)));

  assert_ptr_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (ptr[2:0] == 3'b000 && ptr[AW-1:3] == $past(base_val[AW-1:3])));
endmodule

// File: rtl/rxwb_fill_ctr.sv
module rxwb_fill_ctr #(
  parameter int BUF_BYTES = 1536,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign at_last = (cnt_q == CW'(BUF_BYTES - 1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(BUF_BYTES)) |-> !inc);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BUF_BYTES));
endmodule

// File: rtl/rxwb_seq.sv
module rxwb_seq
  import rxwb_pkg::*;
#(
  parameter int BUF_BYTES = 1536,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          base_we,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_wstrb,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  input  logic [31:0]   ptr,
  output logic          adv,
  output logic          wrap_o,
  input  logic [CW-1:0] cnt,
  input  logic          at_last,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          bna
);
  rxwb_state_e state, nxt;
  logic [29:0] buf_q;
  logic        wrap_q, first_q, last_q, eof_q, bna_q;
  logic [7:0]  byte_q;
  logic [31:0] byte_addr;

  assign byte_addr = {buf_q, 2'b00} + 32'(cnt);

  always_comb begin
    nxt       = state;
    s_ready   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    adv       = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    case (state)
      ST_IDLE: begin
        s_ready = !(rx_en && s_sof);
        if (s_valid && rx_en && s_sof) nxt = ST_FETCH;
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ptr;
        if (mem_gnt) nxt = mem_rdata[0] ? ST_DROP : ST_RECV;
      end
      ST_RECV: begin
        s_ready = 1'b1;
        if (s_valid) nxt = ST_WBYTE;
      end
      ST_WBYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_wdata = {4{byte_q}};
        mem_wstrb = 4'b0001 << byte_addr[1:0];
        if (mem_gnt) begin
          cnt_inc = 1'b1;
          nxt     = (eof_q || at_last) ? ST_WSTAT : ST_RECV;
        end
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr + 32'd4;
        mem_wdata = mk_status(LEN_W'(cnt), first_q, last_q);
        mem_wstrb = 4'hF;
        if (mem_gnt) nxt = ST_WOWN;
      end
      ST_WOWN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = {buf_q, wrap_q, 1'b1};
        mem_wstrb = 4'hF;
        if (mem_gnt) begin
          adv     = 1'b1;
          cnt_clr = 1'b1;
          nxt     = last_q ? ST_IDLE : ST_FETCH;
        end
      end
      ST_DROP: begin
        s_ready = 1'b1;
        if (s_valid && s_eof) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      buf_q   <= '0;
      wrap_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      eof_q   <= 1'b0;
      byte_q  <= '0;
      bna_q   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && nxt == ST_FETCH) first_q <= 1'b1;
      if (state == ST_FETCH && mem_gnt) begin
        if (mem_rdata[0]) begin
          bna_q <= 1'b1;
        end else begin
          buf_q  <= mem_rdata[31:2];
          wrap_q <= mem_rdata[1];
        end
      end
      if (state == ST_RECV && s_valid) begin
        byte_q <= s_data;
        eof_q  <= s_eof;
      end
      if (state == ST_WBYTE && mem_gnt) last_q <= eof_q;
      if (state == ST_WOWN && mem_gnt) first_q <= 1'b0;
      if (base_we) bna_q <= 1'b0;
    end
  end

  assign wrap_o = wrap_q;
  assign bna    = bna_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  assert_stat_then_own_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WSTAT && mem_gnt) |=> (state == ST_WOWN));

  assert_used_sets_bna_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && mem_gnt && mem_rdata[0] && !base_we) |=> bna);

  assert_disabled_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));

  assert_single_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && state == ST_WBYTE) |-> $onehot0(mem_wstrb) && (mem_wstrb != 4'b0));
endmodule

// File: rtl/rx_ring_wb.sv
module rx_ring_wb #(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        qbase_we,
  input  logic [31:0] qbase_val,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_sof,
  input  logic        s_eof,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_wstrb,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        bna
);
  localparam int CW = $clog2(BUF_BYTES + 1);

  logic [31:0]   ptr;
  logic          adv, wrap;
  logic [CW-1:0] cnt;
  logic          at_last, cnt_clr, cnt_inc;

  rxwb_ring_ptr #(.AW(32)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_we(qbase_we), .base_val(qbase_val),
    .adv(adv), .wrap(wrap), .ptr(ptr)
  );

  rxwb_fill_ctr #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
    .cnt(cnt), .at_last(at_last)
  );

  rxwb_seq #(.BUF_BYTES(BUF_BYTES), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_we(qbase_we),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .ptr(ptr), .adv(adv), .wrap_o(wrap),
    .cnt(cnt), .at_last(at_last), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .bna(bna)
  );
endmodule

// File: tb/rx_ring_wb_tb.sv
`timescale 1ns/1ps
module rx_ring_wb_tb;
  localparam int BUFB  = 16;
  localparam int NDESC = 4;
  localparam logic [31:0] RING = 32'h100;
  localparam logic [31:0] BUFS = 32'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic qbase_we = 1'b0;
  logic [31:0] qbase_val = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_data = '0;
  logic s_sof = 1'b0, s_eof = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_wstrb;
  logic mem_gnt = 1'b0;
  logic bna;

  logic [31:0] mem [0:255];
  logic [31:0] exp_mem [0:255];
  logic [7:0]  fb [0:63];
  int nchk = 0, nfail = 0, wcount = 0, holdviol = 0;
  logic [31:0] e_base, e_addr;
  logic exp_bna = 1'b0;
  logic prev_hold = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;

  always #10 clk = ~clk;

  rx_ring_wb #(.BUF_BYTES(BUFB)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .qbase_we(qbase_we),
    .qbase_val(qbase_val), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .bna(bna)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) mem_gnt <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) begin
      wcount <= wcount + 1;
      for (int l = 0; l < 4; l++)
        if (mem_wstrb[l]) mem[mem_addr[9:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
    end
    if (prev_hold && (!mem_req || mem_addr != prev_addr || mem_wdata != prev_wdata))
      holdviol <= holdviol + 1;
    prev_hold  <= rst_n && mem_req && !mem_gnt;
    prev_addr  <= mem_addr;
    prev_wdata <= mem_wdata;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    qbase_we = 1'b1; qbase_val = b;
    @(negedge clk);
    qbase_we = 1'b0;
    e_base = {b[31:3], 3'b000}; e_addr = e_base; exp_bna = 1'b0;
  endtask

  task automatic give_back(input int d);
    mem[RING[9:2] + 2*d][0] = 1'b0;
    exp_mem[RING[9:2] + 2*d][0] = 1'b0;
  endtask

  task automatic send(input int len, input logic mark);
    logic got;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1; s_data = fb[i];
      s_sof = mark && (i == 0); s_eof = mark && (i == len - 1);
      while (1) begin
        #5 got = s_ready;
        @(negedge clk);
        if (got) break;
      end
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  // Expected ring effect of one enabled frame, from R1..R7.
  task automatic model(input int len);
    int pos, n;
    logic first;
    logic [31:0] w0, ba;
    pos = 0; first = 1'b1;
    while (pos < len) begin
      w0 = exp_mem[e_addr[9:2]];
      if (w0[0]) begin exp_bna = 1'b1; break; end
      n = (len - pos > BUFB) ? BUFB : len - pos;
      ba = {w0[31:2], 2'b00};
      for (int k = 0; k < n; k++) begin
        logic [31:0] a;
        a = ba + 32'(k);
        exp_mem[a[9:2]][8*a[1:0] +: 8] = fb[pos + k];
      end
      exp_mem[e_addr[9:2] + 1] = {16'b0, (pos + n == len), first, 14'(n)};
      exp_mem[e_addr[9:2]] = w0 | 32'd1;
      e_addr = w0[1] ? e_base : e_addr + 32'd8;
      pos += n; first = 1'b0;
    end
  endtask

  task automatic check_all();
    for (int d = 0; d < NDESC; d++) begin
      int w;
      w = RING[9:2] + 2*d;
      check(mem[w] == exp_mem[w], "R3 descriptor word0", mem[w], exp_mem[w]);
      check(mem[w+1] == exp_mem[w+1], "R2 status word", mem[w+1], exp_mem[w+1]);
    end
    for (int w = BUFS[9:2]; w < BUFS[9:2] + NDESC*BUFB/4; w++)
      check(mem[w] == exp_mem[w], "R1 buffer data", mem[w], exp_mem[w]);
    check(bna == exp_bna, "R4 bna flag", 32'(bna), 32'(exp_bna));
  endtask

  task automatic fill(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int wc0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem[i] = 32'hA5A5_0000 + 32'(i); end
    for (int d = 0; d < NDESC; d++) begin
      mem[RING[9:2] + 2*d]     = (BUFS + 32'(d*BUFB)) | ((d == NDESC-1) ? 32'd2 : 32'd0);
      mem[RING[9:2] + 2*d + 1] = 32'h0;
    end
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
    e_base = 0; e_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(mem_req == 1'b0, "R11 reset mem_req", 32'(mem_req), 0);
    check(bna == 1'b0, "R11 reset bna", 32'(bna), 0);
    check(s_ready == 1'b1, "R11 reset s_ready", 32'(s_ready), 1);

    set_base(RING);
    rx_en = 1'b1;
    // R1/R2/R3: short frame
    fill(5); send(5, 1'b1); settle(); model(5); check_all();
    // R7: exact fit
    fill(BUFB); send(BUFB, 1'b1); settle(); model(BUFB); check_all();
    check(mem[RING[9:2] + 3] == 32'h0000_C010, "R7 exact-fit status", mem[RING[9:2]+3], 32'h0000_C010);
    // R6/R5: spans desc2 and wrap desc3
    fill(20); send(20, 1'b1); settle(); model(20); check_all();
    check(mem[RING[9:2] + 5] == 32'h0000_4010, "R6 first span status", mem[RING[9:2]+5], 32'h0000_4010);
    check(mem[RING[9:2] + 7] == 32'h0000_8004, "R6 last span status", mem[RING[9:2]+7], 32'h0000_8004);
    // R4: desc0 still used -> drop
    wc0 = wcount;
    fill(7); send(7, 1'b1); settle(); model(7); check_all();
    check(wcount == wc0, "R4 no writes on drop", 32'(wcount), 32'(wc0));
    check(bna == 1'b1, "R4 bna raised", 32'(bna), 1);
    // R10: base write to desc2 clears bna, frame lands there
    for (int d = 0; d < NDESC; d++) give_back(d);
    set_base(RING + 32'h10);
    check(bna == 1'b0, "R4 bna cleared by base write", 32'(bna), 0);
    fill(3); send(3, 1'b1); settle(); model(3); check_all();
    check(mem[RING[9:2] + 4][0] == 1'b1, "R10 frame at new base", mem[RING[9:2]+4], 32'h1);
    // R8: disabled at frame start
    rx_en = 1'b0; wc0 = wcount;
    fill(9); send(9, 1'b1); settle(); check_all();
    check(wcount == wc0, "R8 no writes while disabled", 32'(wcount), 32'(wc0));
    rx_en = 1'b1;
    // R9: stray bytes
    wc0 = wcount;
    fill(6); send(6, 1'b0); settle(); check_all();
    check(wcount == wc0, "R9 stray bytes ignored", 32'(wcount), 32'(wc0));

    // random phase: R1..R6 mixed
    for (int it = 0; it < 40; it++) begin
      int len;
      logic en;
      for (int d = 0; d < NDESC; d++) if ($urandom % 5 != 0) give_back(d);
      if (it % 7 == 0) set_base(RING + 32'(8 * ($urandom % NDESC)));
      len = 1 + int'($urandom % 40);
      en = ($urandom % 6) != 0;
      @(negedge clk); rx_en = en;
      fill(len); send(len, 1'b1); settle();
      if (en) model(len);
      check_all();
    end
    check(holdviol == 0, "R11 request held until grant", 32'(holdviol), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule